// File: doc/BRIEF.md
# Periodic IN Endpoint Transfer Engine

This block controls one periodic IN endpoint (interrupt or isochronous) on the device side of a USB controller. Firmware programs four values through a small register port: the transfer byte count, the packet count, the per-frame multi-count and the largest packet size. It then sets the enable bit. Each IN token addressed to the endpoint gets one answer, one cycle later. The answer is a data packet read from the transmit buffer, a zero-length packet when the buffer does not yet hold the packet, or a NAK while the endpoint is paused or idle.

The engine counts the remaining bytes and packets down as packets leave. It retires the transfer when the count runs out and keeps sticky interrupt flags that firmware clears by writing ones. It also performs the pause-and-stop handshake: firmware requests the NAK state and the stop together, the engine drops the endpoint, clears the stop request itself and flags it. A flush strobe toward the buffer discards stale data before a fresh transfer. Line signalling, CRC, the buffer storage and frame parity are handled elsewhere.

Top module: `pie_endpoint`

## Requirements
- R1: After a synchronous reset, every register reads zero, the endpoint is disabled, no flag is set, `irq` is low and no send, NAK, pop or flush strobe is active.
- R2: A write of CTRL bit 0 (enable) to address 0 checks the programmed values. The largest packet size must be nonzero, the multi-count must equal the packet count, and the packet count P must satisfy (P-1)·MPS < size ≤ P·MPS, or P = 0 with size 0. On a mismatch, flag bit 4 (config error) is set and the endpoint stays disabled.
- R3: An IN token sampled while the endpoint is enabled and not NAKing produces `tx_send` on the next cycle. `tx_len` is the smaller of the remaining size and the largest packet size, and `buf_pop` pulses with it when the buffer level covers that length.
- R4: Each data packet lowers the remaining size (address 1) by its length and the packet count (address 2) by one.
- R5: When the packet count reaches zero, the enable bit (CTRL bit 0) clears and flag bit 0 (transfer done) sets. An accepted enable with packet count 0 and size 0 sets bit 0 at once and leaves the endpoint disabled.
- R6: A token that arrives while the endpoint is disabled or in the NAK state gets `tx_nak` on the next cycle. No pop occurs and the counts do not change. CTRL bit 1 sets the NAK state, bit 2 clears it, and CTRL read bit 1 shows it.
- R7: When the buffer level is below the packet length, the answer is `tx_send` with `tx_len` 0 and no pop. Flag bit 2 (token while buffer not ready) sets and the counts do not change.
- R8: At the next `sof` pulse after a frame that held a not-ready token, flag bit 3 (incomplete periodic transfer) sets. A frame without one sets nothing.
- R9: A CTRL write with bits 1 and 3 (set NAK and stop) both set turns the NAK state on and shows bit 3 for one cycle. Then bit 3 clears by itself, the enable clears and flag bit 1 (endpoint stopped) sets. Bit 3 written without bit 1 has no effect.
- R10: CTRL bit 4 (flush) produces a one-cycle `buf_flush` pulse on the next cycle.
- R11: Flags at address 5 stay set until a write of one to that bit. A flag event in the same cycle as its clear wins. `irq` is high whenever any flag is set.
- R12: Writes to addresses 1 to 4 are ignored while the endpoint is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 CTRL, 1 size, 2 packets, 3 multi-count, 4 largest packet, 5 flags) |
| cfg_wdata | input | XFER_W | Write data |
| cfg_rdata | output | XFER_W | Read data for `cfg_addr`, combinational |
| tok_in | input | 1 | IN token for this endpoint, one-cycle pulse |
| sof | input | 1 | Frame start pulse |
| buf_level | input | XFER_W | Bytes currently held in the transmit buffer |
| buf_pop | output | 1 | Consume one packet of `tx_len` bytes from the buffer |
| buf_flush | output | 1 | Discard buffer contents |
| tx_send | output | 1 | Send a data packet (length may be zero) |
| tx_nak | output | 1 | Answer the token with NAK |
| tx_len | output | XFER_W | Length of the data packet |
| irq | output | 1 | Any flag set |

## Verification
The hardest situation to reach from the ports is a flag being raised in the same cycle firmware clears it. This happens when a not-ready token coincides with a write-one-to-clear of flag bit 2. The bench reaches it by enabling a transfer, draining `buf_level` to zero and driving the token pulse and the clear write on the same falling edge. It also sequences a not-ready token inside a frame followed by `sof`, so the incomplete flag is seen to rise only at the frame boundary. A cycle model runs alongside to check every strobe in both situations.

// File: rtl/pie_pkg.sv
package pie_pkg;

    localparam int DEF_XFER_W = 12;
    localparam int DEF_PKT_W  = 4;
    localparam int DEF_MPS_W  = 7;
    localparam int ADDR_W     = 3;

    // register addresses
    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_XFER = 3'd1,
        RA_PKT  = 3'd2,
        RA_MC   = 3'd3,
        RA_MPS  = 3'd4,
        RA_IRQ  = 3'd5
    } reg_addr_e;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_SNAK  = 1;
    localparam int CB_CNAK  = 2;
    localparam int CB_DIS   = 3;
    localparam int CB_FLUSH = 4;

    // flag bit positions
    localparam int NIRQ     = 5;
    localparam int IB_DONE  = 0;
    localparam int IB_DISD  = 1;
    localparam int IB_NRDY  = 2;
    localparam int IB_INCMP = 3;
    localparam int IB_CFG   = 4;

    typedef struct packed {
        logic flush;
        logic dis;
        logic cnak;
        logic snak;
        logic en;
    } ctrl_cmd_t;

    // n full packets plus a short remainder: count must be ceil(size/mps)
    function automatic logic count_ok(input int xfer, input int mps, input int pkt);
        if (mps == 0) return 1'b0;
        if (pkt == 0) return (xfer == 0);
        return (xfer > (pkt - 1) * mps) && (xfer <= pkt * mps);
    endfunction

endpackage

// File: rtl/pie_cfg_check.sv
module pie_cfg_check #(
    parameter int XFER_W = pie_pkg::DEF_XFER_W,
    parameter int PKT_W  = pie_pkg::DEF_PKT_W,
    parameter int MPS_W  = pie_pkg::DEF_MPS_W
) (
    input  logic [XFER_W-1:0] xfer,
    input  logic [PKT_W-1:0]  pkt,
    input  logic [PKT_W-1:0]  mc,
    input  logic [MPS_W-1:0]  mps,
    output logic              ok
);
    logic count_good;

    always_comb begin
        count_good = pie_pkg::count_ok(int'(xfer), int'(mps), int'(pkt));
        ok         = count_good && (mc == pkt);
    end
endmodule

// File: rtl/pie_irq.sv
module pie_irq #(
    parameter int N = pie_pkg::NIRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] keep;

    always_comb begin
        keep = clr_we ? (flags & ~clr_mask) : flags;
        irq  = |flags;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= keep | set_ev;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !(clr_we && clr_mask[i])) |=> flags[i]);
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> flags[i]);
    end
endmodule

// File: rtl/pie_tx_engine.sv
module pie_tx_engine #(
    parameter int XFER_W = pie_pkg::DEF_XFER_W,
    parameter int PKT_W  = pie_pkg::DEF_PKT_W,
    parameter int MPS_W  = pie_pkg::DEF_MPS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  pie_pkg::ctrl_cmd_t       cmd,
    input  logic                     wr_xfer,
    input  logic                     wr_pkt,
    input  logic                     wr_mc,
    input  logic                     wr_mps,
    input  logic [XFER_W-1:0]        wdata,
    input  logic                     tok_in,
    input  logic                     sof,
    input  logic [XFER_W-1:0]        buf_level,
    input  logic                     cfg_ok,
    output logic [XFER_W-1:0]        xfer_q,
    output logic [PKT_W-1:0]         pkt_q,
    output logic [PKT_W-1:0]         mc_q,
    output logic [MPS_W-1:0]         mps_q,
    output logic                     en_q,
    output logic                     nak_q,
    output logic                     dis_q,
    output logic                     tx_send,
    output logic                     tx_nak,
    output logic                     buf_pop,
    output logic                     buf_flush,
    output logic [XFER_W-1:0]        tx_len,
    output logic [pie_pkg::NIRQ-1:0] ev
);
    import pie_pkg::*;

    logic [XFER_W-1:0] mps_ext, len_c;
    logic serve, ready, good, short_c, finish;
    logic dis_req, en_req, start_empty, miss_q;

    always_comb begin
        mps_ext     = XFER_W'(mps_q);
        len_c       = (xfer_q < mps_ext) ? xfer_q : mps_ext;
        serve       = tok_in && en_q && !nak_q;
        ready       = (buf_level >= len_c);
        good        = serve && ready;
        short_c     = serve && !ready;
        finish      = good && (pkt_q == PKT_W'(1));
        dis_req     = cmd_valid && cmd.snak && cmd.dis;
        en_req      = cmd_valid && cmd.en && !dis_req && !en_q && !dis_q;
        start_empty = en_req && cfg_ok && (pkt_q == '0);
        ev            = '0;
        ev[IB_DONE]   = finish || start_empty;
        ev[IB_DISD]   = dis_q;
        ev[IB_NRDY]   = short_c;
        ev[IB_INCMP]  = sof && miss_q;
        ev[IB_CFG]    = en_req && !cfg_ok;
    end

    // token answer path
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_send   <= 1'b0;
            tx_nak    <= 1'b0;
            buf_pop   <= 1'b0;
            buf_flush <= 1'b0;
            tx_len    <= '0;
        end else begin
            tx_send   <= serve;
            tx_nak    <= tok_in && !serve;
            buf_pop   <= good;
            buf_flush <= cmd_valid && cmd.flush;
            tx_len    <= good ? len_c : '0;
        end
    end

    // transfer counters and programmed values
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= '0;
            pkt_q  <= '0;
            mc_q   <= '0;
            mps_q  <= '0;
        end else if (good) begin
            xfer_q <= xfer_q - len_c;
            pkt_q  <= pkt_q - PKT_W'(1);
        end else if (!en_q) begin
            if (wr_xfer) xfer_q <= wdata;
            if (wr_pkt)  pkt_q  <= wdata[PKT_W-1:0];
            if (wr_mc)   mc_q   <= wdata[PKT_W-1:0];
            if (wr_mps)  mps_q  <= wdata[MPS_W-1:0];
        end
    end

    // endpoint state
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            nak_q  <= 1'b0;
            dis_q  <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            if (dis_q || finish)
                en_q <= 1'b0;
            else if (en_req && cfg_ok && (pkt_q != '0))
                en_q <= 1'b1;

            if (dis_q)        dis_q <= 1'b0;
            else if (dis_req) dis_q <= 1'b1;

            if (dis_req)                       nak_q <= 1'b1;
            else if (cmd_valid && cmd.cnak)    nak_q <= 1'b0;
            else if (cmd_valid && cmd.snak)    nak_q <= 1'b1;

            if (sof)          miss_q <= short_c;
            else if (short_c) miss_q <= 1'b1;
        end
    end

    assert_pop_has_send_R3: assert property (@(posedge clk) disable iff (rst)
        buf_pop |-> tx_send);
    assert_len_within_mps_R3: assert property (@(posedge clk) disable iff (rst)
        tx_send |-> (tx_len <= mps_ext));
    assert_pop_count_R4: assert property (@(posedge clk) disable iff (rst)
        buf_pop |-> (pkt_q == PKT_W'($past(pkt_q) - PKT_W'(1))));
    assert_zero_count_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (buf_pop && pkt_q == '0) |-> !en_q);
    assert_send_nak_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(tx_send && tx_nak));
    assert_nak_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
        tx_nak |-> !buf_pop);
    assert_dis_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
        dis_q |=> (!dis_q && !en_q));
    assert_enable_checked_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(cfg_ok));
endmodule

// File: rtl/pie_endpoint.sv
module pie_endpoint #(
    parameter int XFER_W = pie_pkg::DEF_XFER_W,
    parameter int PKT_W  = pie_pkg::DEF_PKT_W,
    parameter int MPS_W  = pie_pkg::DEF_MPS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [pie_pkg::ADDR_W-1:0] cfg_addr,
    input  logic [XFER_W-1:0]          cfg_wdata,
    output logic [XFER_W-1:0]          cfg_rdata,
    input  logic                       tok_in,
    input  logic                       sof,
    input  logic [XFER_W-1:0]          buf_level,
    output logic                       buf_pop,
    output logic                       buf_flush,
    output logic                       tx_send,
    output logic                       tx_nak,
    output logic [XFER_W-1:0]          tx_len,
    output logic                       irq
);
    import pie_pkg::*;

    localparam int CTRL_W = CB_FLUSH + 1;

    reg_addr_e         addr_e;
    ctrl_cmd_t         cmd;
    logic              cmd_valid, wr_xfer, wr_pkt, wr_mc, wr_mps, clr_we, cfg_ok;
    logic [XFER_W-1:0] xfer_q;
    logic [PKT_W-1:0]  pkt_q, mc_q;
    logic [MPS_W-1:0]  mps_q;
    logic              en_q, nak_q, dis_q;
    logic [NIRQ-1:0]   ev, flags;

    always_comb begin
        addr_e    = reg_addr_e'(cfg_addr);
        cmd       = ctrl_cmd_t'(cfg_wdata[CTRL_W-1:0]);
        cmd_valid = cfg_wr && (addr_e == RA_CTRL);
        wr_xfer   = cfg_wr && (addr_e == RA_XFER);
        wr_pkt    = cfg_wr && (addr_e == RA_PKT);
        wr_mc     = cfg_wr && (addr_e == RA_MC);
        wr_mps    = cfg_wr && (addr_e == RA_MPS);
        clr_we    = cfg_wr && (addr_e == RA_IRQ);
    end

    always_comb begin
        cfg_rdata = '0;
        case (addr_e)
            RA_CTRL: begin
                cfg_rdata[CB_EN]   = en_q;
                cfg_rdata[CB_SNAK] = nak_q;
                cfg_rdata[CB_DIS]  = dis_q;
            end
            RA_XFER: cfg_rdata = xfer_q;
            RA_PKT:  cfg_rdata = XFER_W'(pkt_q);
            RA_MC:   cfg_rdata = XFER_W'(mc_q);
            RA_MPS:  cfg_rdata = XFER_W'(mps_q);
            RA_IRQ:  cfg_rdata = XFER_W'(flags);
            default: cfg_rdata = '0;
        endcase
    end

    pie_cfg_check #(.XFER_W(XFER_W), .PKT_W(PKT_W), .MPS_W(MPS_W)) u_check (
        .xfer(xfer_q), .pkt(pkt_q), .mc(mc_q), .mps(mps_q), .ok(cfg_ok)
    );

    pie_tx_engine #(.XFER_W(XFER_W), .PKT_W(PKT_W), .MPS_W(MPS_W)) u_eng (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_xfer(wr_xfer), .wr_pkt(wr_pkt), .wr_mc(wr_mc), .wr_mps(wr_mps),
        .wdata(cfg_wdata),
        .tok_in(tok_in), .sof(sof), .buf_level(buf_level), .cfg_ok(cfg_ok),
        .xfer_q(xfer_q), .pkt_q(pkt_q), .mc_q(mc_q), .mps_q(mps_q),
        .en_q(en_q), .nak_q(nak_q), .dis_q(dis_q),
        .tx_send(tx_send), .tx_nak(tx_nak), .buf_pop(buf_pop),
        .buf_flush(buf_flush), .tx_len(tx_len), .ev(ev)
    );

    pie_irq #(.N(NIRQ)) u_irq (
        .clk(clk), .rst(rst),
        .set_ev(ev), .clr_we(clr_we), .clr_mask(cfg_wdata[NIRQ-1:0]),
        .flags(flags), .irq(irq)
    );

    assert_locked_regs_R12: assert property (@(posedge clk) disable iff (rst)
        (en_q && !buf_pop && $past(en_q)) |-> $stable(mps_q));
endmodule

// File: tb/tb_pie_endpoint.sv
module tb_pie_endpoint;
    localparam int XW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [XW-1:0] cfg_wdata = '0;
    logic [XW-1:0] cfg_rdata;
    logic          tok_in = 1'b0, sof = 1'b0;
    logic [XW-1:0] buf_level = '0;
    logic          buf_pop, buf_flush, tx_send, tx_nak, irq;
    logic [XW-1:0] tx_len;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    pie_endpoint dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tok_in(tok_in), .sof(sof),
        .buf_level(buf_level), .buf_pop(buf_pop), .buf_flush(buf_flush),
        .tx_send(tx_send), .tx_nak(tx_nak), .tx_len(tx_len), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    int m_en, m_nak, m_dis, m_xfer, m_pkt, m_mc, m_mps, m_flags, m_miss;
    int o_send, o_nak, o_pop, o_len, o_flush;

    function automatic int legal(int x, int p, int c, int s);
        if (s == 0 || c != p) return 0;
        if (p == 0) return (x == 0) ? 1 : 0;
        return (x > (p - 1) * s && x <= p * s) ? 1 : 0;
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_en + 2 * m_nak + 8 * m_dis;
            1: return m_xfer;
            2: return m_pkt;
            3: return m_mc;
            4: return m_mps;
            5: return m_flags;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_nak = 0; m_dis = 0; m_xfer = 0; m_pkt = 0; m_mc = 0;
            m_mps = 0; m_flags = 0; m_miss = 0;
            o_send = 0; o_nak = 0; o_pop = 0; o_len = 0; o_flush = 0;
        end else begin
            int en0, dis0, nak0, evs, clr, miss_now, want;
            en0 = m_en; dis0 = m_dis; nak0 = m_nak; evs = 0; miss_now = 0;
            o_send = 0; o_nak = 0; o_pop = 0; o_len = 0; o_flush = 0;
            clr = (cfg_wr && cfg_addr == 5) ? int'(cfg_wdata) : 0;
            if (tok_in) begin
                if (!en0 || nak0) o_nak = 1;
                else begin
                    want = (m_xfer < m_mps) ? m_xfer : m_mps;
                    o_send = 1;
                    if (int'(buf_level) < want) begin
                        evs |= 4; miss_now = 1;
                    end else begin
                        o_len = want; o_pop = 1;
                        m_xfer -= want; m_pkt -= 1;
                        if (m_pkt == 0) begin m_en = 0; evs |= 1; end
                    end
                end
            end
            if (sof) begin
                if (m_miss) evs |= 8;
                m_miss = miss_now;
            end else if (miss_now) m_miss = 1;
            if (dis0) begin m_en = 0; m_dis = 0; evs |= 2; end
            if (cfg_wr) begin
                case (int'(cfg_addr))
                    0: begin
                        if (cfg_wdata[1] && cfg_wdata[3]) begin
                            m_nak = 1; if (!dis0) m_dis = 1;
                        end else begin
                            if (cfg_wdata[1]) m_nak = 1;
                            if (cfg_wdata[2]) m_nak = 0;
                            if (cfg_wdata[0] && !en0 && !dis0) begin
                                if (!legal(m_xfer, m_pkt, m_mc, m_mps)) evs |= 16;
                                else if (m_pkt == 0) evs |= 1;
                                else m_en = 1;
                            end
                        end
                        if (cfg_wdata[4]) o_flush = 1;
                    end
                    1: if (!en0) m_xfer = int'(cfg_wdata);
                    2: if (!en0 && !o_pop) m_pkt = int'(cfg_wdata[3:0]);
                    3: if (!en0) m_mc = int'(cfg_wdata[3:0]);
                    4: if (!en0) m_mps = int'(cfg_wdata[6:0]);
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | evs;
        end
    end

    // per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            #2;
            chk("R3 tx_send", int'(tx_send), o_send);
            chk("R3 tx_len", int'(tx_len), o_len);
            chk("R6 tx_nak", int'(tx_nak), o_nak);
            chk("R4 buf_pop", int'(buf_pop), o_pop);
            chk("R10 buf_flush", int'(buf_flush), o_flush);
            chk("R11 irq", int'(irq), (m_flags != 0) ? 1 : 0);
            chk("R12 readback", int'(cfg_rdata), model_read(int'(cfg_addr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = XW'(d);
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); cfg_addr = 3'(a); #3; v = int'(cfg_rdata);
    endtask

    task automatic token();
        @(negedge clk); tok_in = 1'b1;
        @(negedge clk); tok_in = 1'b0; #3;
    endtask

    task automatic frame();
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
    endtask

    task automatic setup(input int x, input int p, input int c, input int s);
        wr(4, s); wr(1, x); wr(2, p); wr(3, c);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v); chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq", int'(irq), 0);

        // R2 config mismatch: 20 bytes at 8 needs 3 packets
        setup(20, 2, 2, 8); wr(0, 1);
        rd(5, v); chk("R2 cfg error flag", v, 16);
        rd(0, v); chk("R2 stays disabled", v, 0);
        wr(2, 3); wr(3, 2); wr(0, 1);
        rd(0, v); chk("R2 multi-count mismatch", v, 0);
        wr(5, 16); rd(5, v); chk("R11 clear by write one", v, 0);

        // R3 R4 R5 normal transfer 8+8+4
        wr(3, 3); wr(0, 1);
        rd(0, v); chk("R2 legal enable", v, 1);
        wr(1, 5); rd(1, v); chk("R12 write ignored while enabled", v, 20);
        buf_level = 64;
        token(); chk("R3 first length", int'(tx_len), 8);
        rd(1, v); chk("R4 remaining size", v, 12);
        rd(2, v); chk("R4 remaining count", v, 2);
        token(); chk("R3 second length", int'(tx_len), 8);
        token(); chk("R3 short last length", int'(tx_len), 4);
        rd(0, v); chk("R5 enable cleared", v, 0);
        rd(5, v); chk("R5 done flag", v, 1);
        wr(5, 31);

        // R7 R8 not-ready token and incomplete frame
        setup(16, 2, 2, 8); wr(0, 1);
        buf_level = 4;
        token();
        chk("R7 zero-length send", int'(tx_send) * 100 + int'(tx_len), 100);
        chk("R7 no pop", int'(buf_pop), 0);
        rd(5, v); chk("R7 not-ready flag", v, 4);
        rd(2, v); chk("R7 count unchanged", v, 2);
        frame(); rd(5, v); chk("R8 incomplete at frame start", v, 12);
        wr(5, 12); frame(); rd(5, v); chk("R8 clean frame sets nothing", v, 0);
        buf_level = 64;
        token(); token();
        rd(5, v); chk("R5 done after recovery", v, 1);
        wr(5, 31);

        // R6 NAK state and disabled endpoint
        setup(8, 1, 1, 8); wr(0, 2); wr(0, 1);
        token(); chk("R6 nak while paused", int'(tx_nak), 1);
        rd(2, v); chk("R6 count unchanged", v, 1);
        wr(0, 4); token(); chk("R6 data after nak cleared", int'(tx_len), 8);
        token(); chk("R6 nak while disabled", int'(tx_nak), 1);
        wr(5, 31);

        // R9 stop handshake
        setup(16, 2, 2, 8); wr(0, 1);
        wr(0, 8); rd(0, v); chk("R9 stop alone ignored", v, 1);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = XW'(10);
        @(negedge clk); cfg_wr = 1'b0; #3;
        chk("R9 stop pending visible", int'(cfg_rdata), 11);
        @(negedge clk); #3;
        chk("R9 stop self-cleared", int'(cfg_rdata), 2);
        rd(5, v); chk("R9 stopped flag", v, 2);
        wr(5, 31);

        // R10 flush
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = XW'(16);
        @(negedge clk); cfg_wr = 1'b0; #3;
        chk("R10 flush pulse", int'(buf_flush), 1);
        @(negedge clk); #3; chk("R10 flush one cycle", int'(buf_flush), 0);

        // R5 empty transfer
        wr(0, 4); setup(0, 0, 0, 8); wr(0, 1);
        rd(0, v); chk("R5 empty stays disabled", v, 0);
        rd(5, v); chk("R5 empty done", v, 1);
        wr(5, 31);

        // R11 set wins over clear in the same cycle
        setup(8, 1, 1, 8); wr(0, 1);
        buf_level = 0;
        @(negedge clk); tok_in = 1'b1; cfg_wr = 1'b1; cfg_addr = 3'd5; cfg_wdata = XW'(4);
        @(negedge clk); tok_in = 1'b0; cfg_wr = 1'b0;
        rd(5, v); chk("R11 set wins over clear", v, 4);
        chk("R11 irq follows flags", int'(irq), 1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule